// File: doc/BRIEF.md
# Calibrated Range Activation Quantizer

This block lowers the precision of signed activation words using a range measured ahead of time. Two limits are fixed as parameters when a layer's instance is built, a lower limit and an upper limit. The span between them is split into 2^IDX_W equal buckets. An input outside the span is first forced to the nearer limit and flagged. The input is then assigned a bucket number, and the block outputs that number together with the centre of the bucket, which serves as the reconstructed activation for the next layer.

The bucket number comes from a constant reciprocal of the bucket width, computed at elaboration. No divider is built. The reciprocal carries enough fraction bits to give the exact floor for every in-range offset. The datapath is a three-stage pipeline with a valid/ready handshake on each side. It takes one input per cycle and holds its state while the consumer stalls.

Top module: `act_quantizer`

## Requirements
- R1: An input below LO (signed two's complement compare) yields out_index = 0 and out_clipped = 1.
- R2: An input above HI yields out_index = 2^IDX_W-1 and out_clipped = 1.
- R3: An input x with LO <= x <= HI yields out_clipped = 0 and out_index = floor((x-LO)*2^IDX_W/(HI-LO)), limited to 2^IDX_W-1, so x = HI lands in the top bucket.
- R4: out_value equals LO + floor((2*out_index+1)*(HI-LO)/2^(IDX_W+1)), the bucket centre, as a signed DATA_W-bit word, and it always lies between LO and HI.
- R5: With out_ready held high, a word accepted on a clock edge is presented with out_valid = 1 after the third rising edge, counting the accepting edge, and not earlier.
- R6: While out_valid = 1 and out_ready = 0, in_ready is 0 and out_index, out_value and out_clipped stay unchanged.
- R7: During reset and in the first cycle after it, out_valid is 0.
- R8: Every accepted input produces exactly one output, in acceptance order, with none lost or duplicated under stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input this cycle |
| in_data | input | DATA_W | Signed activation to quantize |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_index | output | IDX_W | Bucket number |
| out_value | output | DATA_W | Signed bucket centre |
| out_clipped | output | 1 | Input was outside [LO, HI] |

## Verification
Each result appears three rising edges after its input is accepted, provided the consumer stays ready. The bench changes inputs on the falling edge and evaluates both handshakes one nanosecond later, so it records exactly the transfers the next rising edge performs. Expected results go into a queue in acceptance order and are compared when the matching output handshake occurs. This ordering stays correct however long a stall lasts. A directed sequence counts edges after a single accepted word to confirm out_valid is low after the first and second edges and high after the third. A stall sequence compares the held outputs against a snapshot on every stalled cycle.

// File: rtl/aq_pkg.sv
package aq_pkg;
    // Reciprocal of (span / 2^idx_w) scaled by 2^frac, rounded up.
    function automatic longint recip_calc(input int span, input int shift);
        return ((longint'(1) <<< shift) + longint'(span) - longint'(1)) / longint'(span);
    endfunction
endpackage

// File: rtl/aq_clip.sv
module aq_clip #(
    parameter int DATA_W = 16,
    parameter int LO     = -1000,
    parameter int HI     = 3000,
    parameter int RW     = 12
) (
    input  logic [DATA_W-1:0] x,
    output logic [RW-1:0]     ofs,
    output logic              clip
);
    logic signed [31:0] xs;
    logic signed [31:0] diff;

    always_comb begin
        xs   = {{(32-DATA_W){x[DATA_W-1]}}, x};
        diff = xs - 32'(LO);
        clip = 1'b0;
        if (xs < 32'(LO)) begin
            diff = '0;
            clip = 1'b1;
        end else if (xs > 32'(HI)) begin
            diff = 32'(HI - LO);
            clip = 1'b1;
        end
        ofs = diff[RW-1:0];
    end
endmodule

// File: rtl/aq_bucket.sv
module aq_bucket #(
    parameter int IDX_W = 4,
    parameter int RW    = 12,
    parameter int FRAC  = 24,
    parameter int SPAN  = 4000
) (
    input  logic [RW-1:0]    ofs,
    output logic [IDX_W-1:0] idx
);
    localparam int PW = RW + FRAC + IDX_W + 1;
    localparam longint RECIP = aq_pkg::recip_calc(SPAN, FRAC + IDX_W);
    localparam logic [PW-1:0] RECIP_C = PW'(RECIP);
    localparam logic [PW-1:0] TOP_C = PW'((1 << IDX_W) - 1);

    logic [PW-1:0] prod;
    logic [PW-1:0] q;

    always_comb begin
        prod = PW'(ofs) * RECIP_C;
        q    = prod >> FRAC;
        idx  = (q > TOP_C) ? TOP_C[IDX_W-1:0] : q[IDX_W-1:0];
    end
endmodule

// File: rtl/aq_midpoint.sv
module aq_midpoint #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int LO     = -1000,
    parameter int SPAN   = 4000
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] val
);
    logic [31:0] num;
    logic [31:0] sum;

    always_comb begin
        num = (32'(idx) * 32'd2 + 32'd1) * 32'(SPAN);
        sum = 32'(LO) + (num >> (IDX_W + 1));
        val = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/act_quantizer.sv
module act_quantizer #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int LO     = -1000,
    parameter int HI     = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_index,
    output logic [DATA_W-1:0] out_value,
    output logic              out_clipped
);
    localparam int SPAN = HI - LO;
    localparam int RW   = $clog2(SPAN + 1);
    localparam int FRAC = 2 * RW;

    typedef struct packed {
        logic          vld;
        logic          clip;
        logic [RW-1:0] ofs;
    } st1_t;

    typedef struct packed {
        logic             vld;
        logic             clip;
        logic [IDX_W-1:0] idx;
    } st2_t;

    typedef struct packed {
        logic              vld;
        logic              clip;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  adv;
    logic [RW-1:0]     ofs_c;
    logic              clip_c;
    logic [IDX_W-1:0]  idx_c;
    logic [DATA_W-1:0] val_c;

    aq_clip #(.DATA_W(DATA_W), .LO(LO), .HI(HI), .RW(RW)) u_clip (
        .x(in_data), .ofs(ofs_c), .clip(clip_c)
    );

    aq_bucket #(.IDX_W(IDX_W), .RW(RW), .FRAC(FRAC), .SPAN(SPAN)) u_bucket (
        .ofs(pipe_q.s1.ofs), .idx(idx_c)
    );

    aq_midpoint #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LO(LO), .SPAN(SPAN)) u_mid (
        .idx(pipe_q.s2.idx), .val(val_c)
    );

    assign adv = !pipe_q.s3.vld || out_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (adv) begin
            pipe_d.s1.vld  = in_valid;
            pipe_d.s1.clip = clip_c;
            pipe_d.s1.ofs  = ofs_c;
            pipe_d.s2.vld  = pipe_q.s1.vld;
            pipe_d.s2.clip = pipe_q.s1.clip;
            pipe_d.s2.idx  = idx_c;
            pipe_d.s3.vld  = pipe_q.s2.vld;
            pipe_d.s3.clip = pipe_q.s2.clip;
            pipe_d.s3.idx  = pipe_q.s2.idx;
            pipe_d.s3.val  = val_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign in_ready    = adv;
    assign out_valid   = pipe_q.s3.vld;
    assign out_index   = pipe_q.s3.idx;
    assign out_value   = pipe_q.s3.val;
    assign out_clipped = pipe_q.s3.clip;

    // Cycles since reset release, saturating, so latency checks never look before reset.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_index)
                                    && $stable(out_value) && $stable(out_clipped));

    // R6
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R1
    clip_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_clipped |-> (out_index == '0) || (out_index == '1));

    // R4
    value_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_value) >= LO) && ($signed(out_value) <= HI));

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) && $past(in_valid && in_ready, 3) && $past(out_ready, 1)
        && $past(out_ready, 2) && $past(out_ready, 3) |-> out_valid);

    // R7
    post_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> !out_valid);
endmodule

// File: tb/sim_act_quantizer.sv
`timescale 1ns/1ps
module sim_act_quantizer;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 4;
    localparam int LO     = -1000;
    localparam int HI     = 3000;
    localparam int TOP    = (1 << IDX_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [IDX_W-1:0] out_index;
    logic [DATA_W-1:0] out_value;
    logic out_clipped;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int q_x[$];

    always #10 clk = ~clk;

    act_quantizer #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LO(LO), .HI(HI)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_index(out_index), .out_value(out_value), .out_clipped(out_clipped)
    );

    function automatic int exp_idx(input int x);
        int xc, i;
        xc = (x < LO) ? LO : ((x > HI) ? HI : x);
        i = ((xc - LO) * (1 << IDX_W)) / (HI - LO);
        if (i > TOP) i = TOP;
        return i;
    endfunction

    function automatic int exp_val(input int i);
        return LO + ((2 * i + 1) * (HI - LO)) / (1 << (IDX_W + 1));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pop_check();
        int x, ei, ev;
        bit ec;
        if (q_x.size() == 0) begin
            check(1'b0, "R8 unexpected output", 1, 0);
            return;
        end
        x  = q_x.pop_front();
        ei = exp_idx(x);
        ev = exp_val(ei);
        ec = (x < LO) || (x > HI);
        if (x < LO)      check(out_index == ei && out_clipped == ec, "R1 R8 index/clip", int'(out_index), ei);
        else if (x > HI) check(out_index == ei && out_clipped == ec, "R2 R8 index/clip", int'(out_index), ei);
        else             check(out_index == ei && out_clipped == ec, "R3 R8 index/clip", int'(out_index), ei);
        check(int'($signed(out_value)) == ev, "R4 value", int'($signed(out_value)), ev);
    endtask

    task automatic step(input bit iv, input int x, input bit ordy);
        @(negedge clk);
        in_valid  = iv;
        in_data   = DATA_W'(x);
        out_ready = ordy;
        #1;
        if (out_valid && out_ready) pop_check();
        if (in_valid && in_ready) q_x.push_back(x);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int snap_i, snap_v;
        bit snap_c;
        int dir[$];
        void'($urandom(32'd2718));
        dir = '{LO, LO - 1, HI, HI + 1, HI - 1, LO + 250, LO + 249, -32768, 32767, 0, 1999, 2000};

        repeat (3) @(negedge clk);
        #1 check(out_valid == 1'b0, "R7 in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check(out_valid == 1'b0, "R7 after reset", int'(out_valid), 0);

        // Directed corner values for R1 R2 R3 R4
        foreach (dir[k]) step(1'b1, dir[k], 1'b1);
        repeat (5) step(1'b0, 0, 1'b1);

        // R5 latency of one isolated word
        step(1'b1, 500, 1'b1);
        step(1'b0, 0, 1'b1);
        check(out_valid == 1'b0, "R5 after edge 1", int'(out_valid), 0);
        step(1'b0, 0, 1'b1);
        check(out_valid == 1'b0, "R5 after edge 2", int'(out_valid), 0);
        step(1'b0, 0, 1'b1);
        check(out_valid == 1'b1, "R5 after edge 3", int'(out_valid), 1);
        repeat (3) step(1'b0, 0, 1'b1);

        // R6 stall: fill with ready low, outputs must hold
        for (int k = 0; k < 4; k++) step(1'b1, -1500 + k * 1300, 1'b0);
        snap_i = int'(out_index);
        snap_v = int'($signed(out_value));
        snap_c = out_clipped;
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 777, 1'b0);
            check(in_ready == 1'b0, "R6 in_ready", int'(in_ready), 0);
            check(out_valid && int'(out_index) == snap_i && int'($signed(out_value)) == snap_v
                  && out_clipped == snap_c, "R6 hold", int'(out_index), snap_i);
        end
        repeat (6) step(1'b0, 0, 1'b1);

        // Random traffic with random backpressure
        for (int k = 0; k < 4000; k++) begin
            step($urandom_range(0, 3) != 0, int'($urandom_range(0, 6000)) - 2000,
                 $urandom_range(0, 3) != 0);
        end
        repeat (10) step(1'b0, 0, 1'b1);
        check(q_x.size() == 0, "R8 drained", q_x.size(), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule